// File: doc/BRIEF.md
# Interrupt Acknowledge Contention Arbiter

This block decides which interrupt source answers an interrupt acknowledge cycle. A small set of peripheral modules and one system-integration module each hold a pending request level (3 bits, 0 meaning no request) and a 4-bit arbitration number. The system-integration module speaks for two kinds of request: its own periodic timer, which returns an internal vector, and requests from the external pins, whose vector must come from a device on the external bus.

When the processor side pulses the acknowledge strobe with a level, every source requesting at exactly that level enters a bit-serial contention on a wired-OR line, most significant bit first, one clock per bit. The survivor supplies the outcome. It can return an internal vector with normal termination, hand the cycle to the external bus and wait for a vector or a timeout, or end in a spurious-interrupt or bus-error outcome.

Top module: `iack_arbiter`

## Requirements
- R1: After a synchronous reset, `term`, `berr`, `spur`, `dup_err`, `ext_cyc` and `busy` are all low, and `vec_out` and `ext_lvl_o` are zero.
- R2: A peripheral contends only if its request level equals the level sampled with `ack_go`. The system-integration module contends only if its timer level or its external level equals that level. A request level of 0 never contends. Peripheral i occupies bits [i*3 +: 3] of `per_lvl`, [i*4 +: 4] of `per_arb` and [i*8 +: 8] of `per_vec`.
- R3: Among the contenders, the one with the largest arbitration number wins. The outcome appears on the outputs exactly 5 clock edges after the edge that samples `ack_go`. When a peripheral wins, `term` pulses with `vec_out` equal to that peripheral's vector.
- R4: Contention runs, with the same latency, even when exactly one source is requesting.
- R5: If the surviving arbitration number is 0, `spur` pulses while `term`, `berr` and `dup_err` stay low.
- R6: If no source contends, `berr` and `spur` pulse together.
- R7: If two or more contenders survive with the same nonzero number, `dup_err` and `berr` pulse, and `term` and `spur` stay low.
- R8: If the system-integration module wins and its timer requests at the acknowledged level, `term` pulses with `vec_out` equal to `tmr_vec`, even if an external request is at the same level.
- R9: If the system-integration module wins with only the external request at the level, `ext_cyc` rises with `ext_lvl_o` equal to the level. A later `ext_done` ends the cycle with `term` and `vec_out` equal to `ext_vec`.
- R10: If `ext_done` is not seen within `TMO_CYC` cycles of `ext_cyc` being high, `ext_cyc` falls and `spur` and `berr` pulse together.
- R11: `term` never coincides with `berr`, `spur` or `dup_err`, and every outcome flag is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_go | input | 1 | Acknowledge strobe, sampled when idle |
| ack_lvl | input | 3 | Level being acknowledged |
| per_lvl | input | N_PERIPH*3 | Peripheral request levels |
| per_arb | input | N_PERIPH*4 | Peripheral arbitration numbers |
| per_vec | input | N_PERIPH*8 | Peripheral vectors |
| sim_arb | input | 4 | System-integration module arbitration number |
| tmr_lvl | input | 3 | Periodic timer request level |
| tmr_vec | input | 8 | Periodic timer vector |
| xreq_lvl | input | 3 | External request level |
| ext_done | input | 1 | External device terminated the cycle |
| ext_vec | input | 8 | Vector returned by the external device |
| busy | output | 1 | Acknowledge in progress |
| term | output | 1 | Normal termination pulse |
| berr | output | 1 | Bus error pulse |
| spur | output | 1 | Spurious-interrupt pulse |
| dup_err | output | 1 | Duplicate arbitration number pulse |
| vec_out | output | 8 | Vector, valid with `term` |
| ext_cyc | output | 1 | Acknowledge driven on external bus |
| ext_lvl_o | output | 3 | Level presented to the external bus |

## Verification
The checks assume that request levels, arbitration numbers and vectors stay still from the strobe until the outcome, and that `ext_done` is raised only while `ext_cyc` is high. The bench sets all configuration at a falling edge before it pulses `ack_go` for one cycle. It changes nothing until the outcome has been seen and the block has gone idle. The external response is driven only inside the external window.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_RES  = 2'd2,
    ST_EXT  = 2'd3
  } iack_st_e;
endpackage

// File: rtl/iack_match.sv
module iack_match #(
  parameter int N_PERIPH = 3,
  parameter int LVL_W    = 3,
  localparam int NSRC    = N_PERIPH + 1
) (
  input  logic [LVL_W-1:0]          ack_lvl,
  input  logic [N_PERIPH*LVL_W-1:0] per_lvl,
  input  logic [LVL_W-1:0]          tmr_lvl,
  input  logic [LVL_W-1:0]          xreq_lvl,
  output logic [NSRC-1:0]           mask,
  output logic                      tmr_hit
);
  logic lvl_ok;
  assign lvl_ok  = (ack_lvl != '0);
  assign tmr_hit = lvl_ok && (tmr_lvl == ack_lvl);
  // source 0 is the system-integration module
  assign mask[0] = tmr_hit || (lvl_ok && (xreq_lvl == ack_lvl));

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
    assign mask[i+1] = lvl_ok && (per_lvl[i*LVL_W +: LVL_W] == ack_lvl);
  end
endmodule

// File: rtl/iack_contend.sv
module iack_contend #(
  parameter int NSRC  = 4,
  parameter int ARB_W = 4,
  localparam int BW   = (ARB_W > 1) ? $clog2(ARB_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [NSRC-1:0]       load_mask,
  input  logic                  step,
  input  logic [BW-1:0]         bit_idx,
  input  logic [NSRC*ARB_W-1:0] arb_flat,
  output logic [NSRC-1:0]       alive
);
  logic [NSRC-1:0] drive;
  logic            line;

  for (genvar i = 0; i < NSRC; i++) begin : g_drv
    assign drive[i] = arb_flat[i*ARB_W + int'(bit_idx)];
  end

  // wired-OR of the bits driven by sources still in contention
  assign line = |(alive & drive);

  always_ff @(posedge clk) begin
    if (rst) begin
      alive <= '0;
    end else if (load) begin
      alive <= load_mask;
    end else if (step) begin
      alive <= alive & ~(~drive & {NSRC{line}});
    end
  end
endmodule

// File: rtl/iack_pick.sv
module iack_pick #(
  parameter int NSRC  = 4,
  parameter int ARB_W = 4,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       alive,
  input  logic [NSRC*ARB_W-1:0] arb_flat,
  output logic [IW-1:0]         win_idx,
  output logic [ARB_W-1:0]      win_arb,
  output logic                  none,
  output logic                  multi
);
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (alive[i]) win_idx = IW'(i);
    end
  end

  assign win_arb = arb_flat[int'(win_idx)*ARB_W +: ARB_W];
  assign none    = (alive == '0);
  assign multi   = ($countones(alive) > 1);
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter #(
  parameter int N_PERIPH = 3,
  parameter int LVL_W    = 3,
  parameter int ARB_W    = 4,
  parameter int VEC_W    = 8,
  parameter int TMO_CYC  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ack_go,
  input  logic [LVL_W-1:0]              ack_lvl,
  input  logic [N_PERIPH*LVL_W-1:0]     per_lvl,
  input  logic [N_PERIPH*ARB_W-1:0]     per_arb,
  input  logic [N_PERIPH*VEC_W-1:0]     per_vec,
  input  logic [ARB_W-1:0]              sim_arb,
  input  logic [LVL_W-1:0]              tmr_lvl,
  input  logic [VEC_W-1:0]              tmr_vec,
  input  logic [LVL_W-1:0]              xreq_lvl,
  input  logic                          ext_done,
  input  logic [VEC_W-1:0]              ext_vec,
  output logic                          busy,
  output logic                          term,
  output logic                          berr,
  output logic                          spur,
  output logic                          dup_err,
  output logic [VEC_W-1:0]              vec_out,
  output logic                          ext_cyc,
  output logic [LVL_W-1:0]              ext_lvl_o
);
  import iack_pkg::*;

  localparam int NSRC = N_PERIPH + 1;
  localparam int BW   = (ARB_W > 1) ? $clog2(ARB_W) : 1;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int TW   = $clog2(TMO_CYC + 1);

  iack_st_e          st;
  logic [LVL_W-1:0]  lvl_q;
  logic              tmr_q;
  logic [BW-1:0]     bit_q;
  logic [TW-1:0]     tcnt;

  logic [NSRC-1:0]       mask;
  logic                  tmr_hit;
  logic [NSRC*ARB_W-1:0] arb_flat;
  logic [NSRC-1:0]       alive;
  logic [IW-1:0]         win_idx;
  logic [ARB_W-1:0]      win_arb;
  logic                  none;
  logic                  multi;
  logic [VEC_W-1:0]      per_win_vec;
  logic                  start;

  assign arb_flat = {per_arb, sim_arb};
  assign start    = (st == ST_IDLE) && ack_go;
  assign busy     = (st != ST_IDLE);

  iack_match #(.N_PERIPH(N_PERIPH), .LVL_W(LVL_W)) u_match (
    .ack_lvl (ack_lvl),
    .per_lvl (per_lvl),
    .tmr_lvl (tmr_lvl),
    .xreq_lvl(xreq_lvl),
    .mask    (mask),
    .tmr_hit (tmr_hit)
  );

  iack_contend #(.NSRC(NSRC), .ARB_W(ARB_W)) u_contend (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_mask(mask),
    .step     (st == ST_ARB),
    .bit_idx  (bit_q),
    .arb_flat (arb_flat),
    .alive    (alive)
  );

  iack_pick #(.NSRC(NSRC), .ARB_W(ARB_W)) u_pick (
    .alive   (alive),
    .arb_flat(arb_flat),
    .win_idx (win_idx),
    .win_arb (win_arb),
    .none    (none),
    .multi   (multi)
  );

  always_comb begin
    per_win_vec = '0;
    for (int i = 0; i < N_PERIPH; i++) begin
      if (win_idx == IW'(i + 1)) per_win_vec = per_vec[i*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      lvl_q     <= '0;
      tmr_q     <= 1'b0;
      bit_q     <= '0;
      tcnt      <= '0;
      term      <= 1'b0;
      berr      <= 1'b0;
      spur      <= 1'b0;
      dup_err   <= 1'b0;
      vec_out   <= '0;
      ext_cyc   <= 1'b0;
      ext_lvl_o <= '0;
    end else begin
      term    <= 1'b0;
      berr    <= 1'b0;
      spur    <= 1'b0;
      dup_err <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ack_go) begin
            lvl_q <= ack_lvl;
            tmr_q <= tmr_hit;
            bit_q <= BW'(ARB_W - 1);
            st    <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (bit_q == '0) st <= ST_RES;
          else             bit_q <= bit_q - 1'b1;
        end
        ST_RES: begin
          st <= ST_IDLE;
          if (none) begin
            berr <= 1'b1;
            spur <= 1'b1;
          end else if (win_arb == '0) begin
            spur <= 1'b1;
          end else if (multi) begin
            dup_err <= 1'b1;
            berr    <= 1'b1;
          end else if (win_idx == '0) begin
            if (tmr_q) begin
              term    <= 1'b1;
              vec_out <= tmr_vec;
            end else begin
              st        <= ST_EXT;
              ext_cyc   <= 1'b1;
              ext_lvl_o <= lvl_q;
              tcnt      <= '0;
            end
          end else begin
            term    <= 1'b1;
            vec_out <= per_win_vec;
          end
        end
        ST_EXT: begin
          if (ext_done) begin
            term      <= 1'b1;
            vec_out   <= ext_vec;
            ext_cyc   <= 1'b0;
            ext_lvl_o <= '0;
            st        <= ST_IDLE;
          end else if (tcnt == TW'(TMO_CYC - 1)) begin
            spur      <= 1'b1;
            berr      <= 1'b1;
            ext_cyc   <= 1'b0;
            ext_lvl_o <= '0;
            st        <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iack_chk.sv
module iack_chk #(
  parameter int TMO_CYC = 16
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic term,
  input logic berr,
  input logic spur,
  input logic dup_err,
  input logic ext_cyc
);
  localparam int CW = $clog2(TMO_CYC + 2);
  logic [CW-1:0] ext_run;

  always_ff @(posedge clk) begin
    if (rst)          ext_run <= '0;
    else if (ext_cyc) ext_run <= ext_run + 1'b1;
    else              ext_run <= '0;
  end

  // R11: normal termination excludes every error flag
  p_term_excl_r11: assert property (@(posedge clk) disable iff (rst)
    term |-> (!berr && !spur && !dup_err));

  // R11: termination is a single-cycle pulse
  p_term_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);

  // R7: a duplicate is reported with a bus error, never as spurious
  p_dup_berr_r7: assert property (@(posedge clk) disable iff (rst)
    dup_err |-> (berr && !spur));

  // R3: an outcome or the external window follows five edges after start
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ##5 (term || berr || spur || ext_cyc));

  // R9: the external window closes only with termination or spurious
  p_ext_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_cyc) |-> (term || spur));

  // R10: the external window never outlasts the timeout
  p_ext_window_r10: assert property (@(posedge clk) disable iff (rst)
    ext_cyc |-> (ext_run < CW'(TMO_CYC)));
endmodule

bind iack_arbiter iack_chk #(.TMO_CYC(TMO_CYC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .term   (term),
  .berr   (berr),
  .spur   (spur),
  .dup_err(dup_err),
  .ext_cyc(ext_cyc)
);

// File: tb/sim_iack_arbiter.sv
module sim_iack_arbiter;
  localparam int TMO = 16;
  localparam int K_VEC = 0, K_ZERO = 1, K_NONE = 2, K_DUP = 3, K_EXT = 4;

  typedef struct packed {
    logic [2:0]  ack;
    logic [8:0]  plvl;
    logic [11:0] parb;
    logic [3:0]  sarb;
    logic [2:0]  tlvl;
    logic [2:0]  xlvl;
    logic [2:0]  kind;
    logic [7:0]  vec;
  } row_t;

  // per-source fields are {p2,p1,p0}
  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{3'd5, {3'd0,3'd0,3'd5}, {4'd0,4'd0,4'd3},   4'd15, 3'd0, 3'd0, 3'd0, 8'h60}, // R4 lone requester
    '{3'd5, {3'd2,3'd5,3'd5}, {4'd15,4'd9,4'd3},  4'd15, 3'd0, 3'd0, 3'd0, 8'h61}, // R3
    '{3'd4, {3'd4,3'd4,3'd4}, {4'd12,4'd10,4'd11},4'd15, 3'd0, 3'd0, 3'd0, 8'h62}, // R3
    '{3'd5, {3'd0,3'd5,3'd6}, {4'd0,4'd1,4'd15},  4'd15, 3'd0, 3'd0, 3'd0, 8'h61}, // R2 level mismatch
    '{3'd3, {3'd0,3'd0,3'd3}, {4'd0,4'd0,4'd14},  4'd15, 3'd3, 3'd3, 3'd0, 8'h40}, // R8 timer first
    '{3'd3, {3'd0,3'd0,3'd0}, {4'd0,4'd0,4'd0},   4'd15, 3'd0, 3'd3, 3'd4, 8'h77}, // R9 external
    '{3'd6, {3'd0,3'd6,3'd0}, {4'd0,4'd8,4'd0},   4'd7,  3'd0, 3'd6, 3'd0, 8'h61}, // R3 beats module
    '{3'd2, {3'd0,3'd0,3'd2}, {4'd0,4'd0,4'd0},   4'd15, 3'd0, 3'd0, 3'd1, 8'h00}, // R5
    '{3'd7, {3'd1,3'd1,3'd1}, {4'd5,4'd5,4'd5},   4'd15, 3'd2, 3'd2, 3'd2, 8'h00}, // R6
    '{3'd1, {3'd1,3'd0,3'd1}, {4'd9,4'd0,4'd9},   4'd15, 3'd0, 3'd0, 3'd3, 8'h00}, // R7
    '{3'd1, {3'd0,3'd1,3'd1}, {4'd0,4'd0,4'd0},   4'd15, 3'd0, 3'd0, 3'd1, 8'h00}, // R5 all zero
    '{3'd4, {3'd0,3'd0,3'd4}, {4'd0,4'd0,4'd15},  4'd15, 3'd4, 3'd0, 3'd3, 8'h00}  // R7 with system module
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_go = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic [8:0] per_lvl = '0;
  logic [11:0] per_arb = '0;
  logic [23:0] per_vec = {8'h62, 8'h61, 8'h60};
  logic [3:0] sim_arb = 4'd15;
  logic [2:0] tmr_lvl = '0;
  logic [7:0] tmr_vec = 8'h40;
  logic [2:0] xreq_lvl = '0;
  logic ext_done = 1'b0;
  logic [7:0] ext_vec = '0;
  logic busy, term, berr, spur, dup_err, ext_cyc;
  logic [7:0] vec_out;
  logic [2:0] ext_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  iack_arbiter #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .ack_go(ack_go), .ack_lvl(ack_lvl),
    .per_lvl(per_lvl), .per_arb(per_arb), .per_vec(per_vec),
    .sim_arb(sim_arb), .tmr_lvl(tmr_lvl), .tmr_vec(tmr_vec),
    .xreq_lvl(xreq_lvl), .ext_done(ext_done), .ext_vec(ext_vec),
    .busy(busy), .term(term), .berr(berr), .spur(spur), .dup_err(dup_err),
    .vec_out(vec_out), .ext_cyc(ext_cyc), .ext_lvl_o(ext_lvl_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flags();
    return {28'd0, term, berr, spur, dup_err};
  endfunction

  // pulses the strobe and returns at the falling edge after the outcome edge
  task automatic strobe(input logic [2:0] lvl);
    ack_lvl = lvl;
    ack_go  = 1'b1;
    @(negedge clk);
    ack_go  = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_row(input row_t r);
    per_lvl  = r.plvl;
    per_arb  = r.parb;
    sim_arb  = r.sarb;
    tmr_lvl  = r.tlvl;
    xreq_lvl = r.xlvl;
    strobe(r.ack);
    case (int'(r.kind))
      K_VEC: begin
        chk(flags() == 8, "R3 flags", flags(), 8);
        chk(vec_out == r.vec, "R3 vector", vec_out, r.vec);
      end
      K_ZERO: chk(flags() == 2, "R5 flags", flags(), 2);
      K_NONE: chk(flags() == 6, "R6 flags", flags(), 6);
      K_DUP:  chk(flags() == 5, "R7 flags", flags(), 5);
      default: begin
        chk(ext_cyc && flags() == 0, "R9 window", {ext_cyc, flags()[3:0]}, 16);
        chk(ext_lvl_o == r.ack, "R9 level", ext_lvl_o, r.ack);
        repeat (2) @(negedge clk);
        ext_done = 1'b1;
        ext_vec  = r.vec;
        @(negedge clk);
        ext_done = 1'b0;
        chk(flags() == 8 && vec_out == r.vec && !ext_cyc, "R9 response",
            vec_out, r.vec);
      end
    endcase
    @(negedge clk);
    chk(flags() == 0, "R11 pulse width", flags(), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({busy, term, berr, spur, dup_err, ext_cyc} == 6'd0, "R1 flags",
        {busy, term, berr, spur, dup_err, ext_cyc}, 0);
    chk(vec_out == 8'd0 && ext_lvl_o == 3'd0, "R1 data", vec_out, 0);

    for (int i = 0; i < NROW; i++) run_row(TBL[i]);

    // R4: contention still takes its full latency with one requester
    per_lvl = {3'd0, 3'd0, 3'd6}; per_arb = {4'd0, 4'd0, 4'd2};
    tmr_lvl = '0; xreq_lvl = '0; sim_arb = 4'd15;
    ack_lvl = 3'd6; ack_go = 1'b1;
    @(negedge clk); ack_go = 1'b0;
    repeat (4) @(negedge clk);
    chk(flags() == 0 && busy, "R4 no early result", flags(), 0);
    @(negedge clk);
    chk(flags() == 8 && vec_out == 8'h60, "R4 result", vec_out, 8'h60);
    repeat (2) @(negedge clk);

    // R2: acknowledged level 0 has no contenders
    per_lvl = '0;
    strobe(3'd0);
    chk(flags() == 6, "R2 level zero", flags(), 6);
    repeat (2) @(negedge clk);

    // R10: external device never answers
    per_lvl = '0; tmr_lvl = '0; xreq_lvl = 3'd5; sim_arb = 4'd15;
    strobe(3'd5);
    chk(ext_cyc == 1'b1, "R10 window open", ext_cyc, 1);
    repeat (TMO - 1) @(negedge clk);
    chk(ext_cyc && flags() == 0, "R10 still waiting", flags(), 0);
    @(negedge clk);
    chk(flags() == 6 && !ext_cyc, "R10 timeout", flags(), 6);
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule